// File: doc/BRIEF.md
# Two-Bank Interleaved Trigger Gate Controller

This controller shares level-1 triggers between two identical front-end readout banks that are fed the same split detector signal. One bank can open its gate for a fresh level-1 accept while the other bank is still waiting for a level-2 verdict, being cleared, or converting. The effect is that a single slow conversion no longer blocks the whole front end.

Each bank moves through four phases: idle, gated (waiting for a level-2 accept), clearing, and converting. A bank that gets no level-2 accept within `L2_WAIT` clock cycles of opening its gate is fast-cleared for `CLR_CYC` cycles and then returns to idle. A bank that does get an accept signals a conversion start and stays busy until its conversion-done input is seen. The block raises a single front-end busy flag only when neither bank is idle. It counts accepted and dropped level-1 triggers so that the dead-time fraction can be measured.

Top module: `flip_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, both banks are idle: all gates, fast clears and conversion starts are low, busy is low, and both counters are zero.
- R2: A level-1 accept that arrives while a bank is idle is given to the idle bank with the lowest index. That bank's gate goes high from the next cycle and stays high for as long as the bank waits for level-2.
- R3: A level-2 accept is given to the bank that has been gated longest. With one gated bank it goes to that bank. With no gated bank it is ignored, and no conversion start or other output changes.
- R4: A gated bank that gets no level-2 accept during its `L2_WAIT` gated cycles drops its gate and then drives its fast clear for exactly `CLR_CYC` cycles before it is idle again.
- R5: The conversion start of a bank is high, for that one cycle, only in the cycle in which a level-2 accept is given to it. The bank then stays busy until its conversion-done input is high. Conversion-done on a bank that is not converting has no effect.
- R6: Front-end busy is high exactly when no bank is idle.
- R7: A level-1 accept that arrives while busy is high is dropped. It opens no gate, and the drop counter increases by one in the next cycle.
- R8: Each level-1 accept given to a bank increases the accept counter by one in the next cycle. Both counters wrap modulo 2^`CW`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l1_acc | input | 1 | Level-1 accept pulse |
| l2_acc | input | 1 | Level-2 accept pulse |
| conv_done | input | 2 | Per-bank conversion finished |
| gate | output | 2 | Per-bank gate, high while waiting for level-2 |
| fclr | output | 2 | Per-bank fast clear |
| conv_start | output | 2 | Per-bank conversion start pulse |
| fe_busy | output | 1 | No bank idle |
| n_acc | output | CW | Accepted level-1 count |
| n_drop | output | CW | Dropped level-1 count |

## Verification
The bench runs the controller through four traffic regimes and compares it with a queue-based model on every cycle.
- Sparse triggers with prompt level-2 accepts show whether bank choice and conversion hand-off are correct.
- Triggers with no level-2 at all exercise the gate timeout and the exact fast-clear length.
- Dense triggers with rare level-2 accepts keep both banks gated together, which exposes errors in oldest-first matching and in drop counting.
- Frequent accepts with slow conversion-done hold both banks in conversion, which tests busy and ignored stray done pulses.

// File: rtl/flip_ctrl.sv
module flip_ctrl #(
  parameter int L2_WAIT = 40,
  parameter int CLR_CYC = 50,
  parameter int CW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l1_acc,
  input  logic          l2_acc,
  input  logic [1:0]    conv_done,
  output logic [1:0]    gate,
  output logic [1:0]    fclr,
  output logic [1:0]    conv_start,
  output logic          fe_busy,
  output logic [CW-1:0] n_acc,
  output logic [CW-1:0] n_drop
);
  localparam int TMAX = (L2_WAIT > CLR_CYC) ? L2_WAIT : CLR_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_CLR, S_CONV} st_t;

  st_t           st  [2];
  logic [TW-1:0] tmr [2];
  logic          older;
  logic [1:0]    idle, wt, l1hit, l2hit;

  assign idle    = {st[1] == S_IDLE, st[0] == S_IDLE};
  assign wt      = {st[1] == S_WAIT, st[0] == S_WAIT};
  assign fe_busy = ~|idle;
  assign l1hit   = !l1_acc ? 2'b00 : idle[0] ? 2'b01 : idle[1] ? 2'b10 : 2'b00;
  assign l2hit   = !l2_acc ? 2'b00 : (wt == 2'b11) ? (older ? 2'b10 : 2'b01) : wt;

  assign gate       = wt;
  assign fclr       = {st[1] == S_CLR, st[0] == S_CLR};
  assign conv_start = l2hit;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st[b]  <= S_IDLE;
        tmr[b] <= '0;
      end else begin
        case (st[b])
          S_IDLE: if (l1hit[b]) begin
            st[b]  <= S_WAIT;
            tmr[b] <= '0;
          end
          S_WAIT: if (l2hit[b]) begin
            st[b] <= S_CONV;
          end else if (tmr[b] == TW'(L2_WAIT - 1)) begin
            st[b]  <= S_CLR;
            tmr[b] <= '0;
          end else begin
            tmr[b] <= tmr[b] + 1'b1;
          end
          S_CLR: if (tmr[b] == TW'(CLR_CYC - 1)) st[b] <= S_IDLE;
                 else tmr[b] <= tmr[b] + 1'b1;
          default: if (conv_done[b]) st[b] <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      older  <= 1'b0;
      n_acc  <= '0;
      n_drop <= '0;
    end else begin
      if (l1hit[0]) older <= wt[1];
      else if (l1hit[1]) older <= !wt[0];
      if (l1_acc) begin
        if (fe_busy) n_drop <= n_drop + 1'b1;
        else         n_acc  <= n_acc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/flip_ctrl_chk.sv
module flip_ctrl_chk #(parameter int CW = 16) (
  input logic          clk,
  input logic          rst_n,
  input logic          l1_acc,
  input logic [1:0]    gate,
  input logic [1:0]    fclr,
  input logic [1:0]    conv_start,
  input logic          fe_busy,
  input logic [CW-1:0] n_acc,
  input logic [CW-1:0] n_drop
);
  p_gate_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate[0]) || $rose(gate[1])) |-> $past(l1_acc));
  p_l2_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(conv_start));
  p_clr_from_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fclr[0]) |-> ($past(gate[0]) && !$past(conv_start[0])));
  p_clr_from_gate1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fclr[1]) |-> ($past(gate[1]) && !$past(conv_start[1])));
  p_gate_clr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate & fclr) == 2'b00);
  p_start_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start & ~gate) == 2'b00);
  p_drop_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_acc && fe_busy) |=> (n_drop == $past(n_drop) + 1'b1) && $stable(n_acc));
  p_acc_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_acc && !fe_busy) |=> (n_acc == $past(n_acc) + 1'b1) && $stable(n_drop));
endmodule

bind flip_ctrl flip_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .l1_acc(l1_acc), .gate(gate), .fclr(fclr),
  .conv_start(conv_start), .fe_busy(fe_busy), .n_acc(n_acc), .n_drop(n_drop));

// File: tb/flip_ctrl_test.sv
module flip_ctrl_test;
  localparam int L2W = 40, CLR = 50, CW = 16;
  logic clk = 0, rst_n = 0, l1_acc = 0, l2_acc = 0;
  logic [1:0] conv_done = 0, gate, fclr, conv_start;
  logic fe_busy;
  logic [CW-1:0] n_acc, n_drop;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flip_ctrl #(.L2_WAIT(L2W), .CLR_CYC(CLR), .CW(CW)) uut (.*);

  // model: 0 idle, 1 gated, 2 clearing, 3 converting
  int ms[2], mt[2], q[$], macc, mdrop;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int tgt2();
    return (l2_acc && q.size() > 0) ? q[0] : -1;
  endfunction

  task automatic compare();
    int g = 0, f = 0, s = 0, t;
    for (int b = 0; b < 2; b++) begin
      if (ms[b] == 1) g |= 1 << b;
      if (ms[b] == 2) f |= 1 << b;
    end
    t = tgt2();
    if (t >= 0) s = 1 << t;
    chk("R2", "gate", gate, g);
    chk("R4", "fclr", fclr, f);
    chk("R3/R5", "conv_start", conv_start, s);
    chk("R6", "fe_busy", fe_busy, (ms[0] != 0 && ms[1] != 0));
    chk("R7", "n_drop", n_drop, mdrop % (1 << CW));
    chk("R8", "n_acc", n_acc, macc % (1 << CW));
  endtask

  task automatic qdel(int b);
    for (int i = 0; i < q.size(); i++) if (q[i] == b) begin q.delete(i); break; end
  endtask

  task automatic step();
    int t2 = tgt2();
    int t1 = -1;
    if (l1_acc) begin
      if (ms[0] == 0) t1 = 0; else if (ms[1] == 0) t1 = 1;
      if (t1 < 0) mdrop++; else macc++;
    end
    for (int b = 0; b < 2; b++) begin
      case (ms[b])
        0: if (t1 == b) begin ms[b] = 1; mt[b] = 0; end
        1: if (t2 == b) begin ms[b] = 3; qdel(b); end
           else if (mt[b] == L2W - 1) begin ms[b] = 2; mt[b] = 0; qdel(b); end
           else mt[b]++;
        2: if (mt[b] == CLR - 1) ms[b] = 0; else mt[b]++;
        default: if (conv_done[b]) ms[b] = 0;
      endcase
    end
    if (t1 >= 0) q.push_back(t1);
  endtask

  initial begin
    int p1[4] = '{5, 10, 50, 20};
    int p2[4] = '{10, 0, 3, 50};
    int pd[4] = '{5, 5, 5, 1};
    void'($urandom(7));
    ms = '{0, 0}; mt = '{0, 0}; macc = 0; mdrop = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "gate", gate, 0); chk("R1", "fclr", fclr, 0);
    chk("R1", "conv_start", conv_start, 0); chk("R1", "fe_busy", fe_busy, 0);
    chk("R1", "n_acc", n_acc, 0); chk("R1", "n_drop", n_drop, 0);
    rst_n = 1;
    for (int ph = 0; ph < 4; ph++) begin
      for (int c = 0; c < 3000; c++) begin
        @(negedge clk);
        l1_acc = ($urandom_range(99) < p1[ph]);
        l2_acc = ($urandom_range(99) < p2[ph]);
        conv_done[0] = ($urandom_range(99) < pd[ph]);
        conv_done[1] = ($urandom_range(99) < pd[ph]);
        #1;
        compare();
        step();
      end
    end
    @(negedge clk);
    l1_acc = 0; l2_acc = 0; conv_done = 0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule